// File: doc/BRIEF.md
# Serial Memory Slave Pin Front End with Pause Control

This block sits between the four pins of a serial memory slave and its command layer. A fast system clock oversamples the serial clock, data-in, select and pause pins through two-flop synchronizers. Edges of the serial clock are then found on the system clock. Input bits are shifted in MSB first on serial clock rises. Output bits are shifted out MSB first on serial clock falls. Each complete byte is reported to the command layer with a one-cycle strobe, along with a running count of bits in the current byte.

The block is driven by a four-state controller: `FE_UNARMED`, `FE_IDLE`, `FE_ACTIVE` and `FE_HOLD`. After reset the controller sits in `FE_UNARMED`, and it moves to `FE_IDLE` only once select has been seen high (arm). From `FE_IDLE`, a low select moves it to `FE_ACTIVE` (select), which clears the bit count and loads the outgoing byte. In `FE_ACTIVE`, a high select returns it to `FE_IDLE` (deselect). A low pause input while the serial clock is low moves it to `FE_HOLD` (pause). In `FE_HOLD`, a high pause input while the serial clock is low returns it to `FE_ACTIVE` (resume), and a high select goes to `FE_IDLE` with the protocol state cleared (abort).

Both clock-idle-low and clock-idle-high bus modes are served. The outgoing byte is taken from `tx_byte_i` at select, and again at every falling clock edge that comes when the bit count is zero. This makes the first bit right in either mode.

Top module: `spi_hold_frontend`

## Requirements
- R1: After reset, `miso_oe_o`, `rx_valid_o`, `selected_o` and `hold_o` are 0 and `bit_cnt_o` is 0.
- R2: A select that is already low during reset is ignored: clock edges produce no byte and `selected_o` stays 0 until select has gone high and then low again.
- R3: Data-in is captured on serial clock rises, MSB first. `bit_cnt_o` counts rises modulo 8. After the 8th rise, `rx_valid_o` pulses for one cycle with the byte on `rx_byte_o`, and `bit_cnt_o` reads 0.
- R4: Data-out shows bit 7 of `tx_byte_i` after select, then the next lower bit after each falling clock edge within the byte. A falling edge with `bit_cnt_o` at 0 reloads from `tx_byte_i`.
- R5: While select is high, `miso_oe_o` is 0.
- R6: Pause begins only while the serial clock is low. A pause request made with the clock high is deferred until the clock is next low.
- R7: While paused, `hold_o` is 1 and `miso_oe_o` is 0. Clock and data-in edges are ignored: no bits are captured or shifted, and `bit_cnt_o` keeps its value.
- R8: Pause ends only when the pause input is high while the serial clock is low. A release made with the clock high keeps the block paused until the clock is low.
- R9: Raising select during a pause clears the protocol state: `selected_o` goes to 0 and `bit_cnt_o` to 0, and the next select starts a fresh byte.
- R10: With the clock idling high, the first falling edge after select presents bit 7 of `tx_byte_i`, and bytes are exchanged exactly as in the idle-low mode.
- R11: Raising select in the middle of a byte discards the partial byte with no strobe and returns `bit_cnt_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock pin |
| mosi_i | input | 1 | Serial data-in pin |
| csn_i | input | 1 | Active-low select pin |
| holdn_i | input | 1 | Active-low pause pin |
| tx_byte_i | input | 8 | Next byte to send, from the command layer |
| rx_byte_o | output | 8 | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe when a byte completes |
| bit_cnt_o | output | 3 | Bits received in the current byte |
| miso_o | output | 1 | Serial data-out value |
| miso_oe_o | output | 1 | Data-out drive enable (0 models high impedance) |
| selected_o | output | 1 | Block is selected (active or paused) |
| hold_o | output | 1 | Block is paused |

## Verification
The bench builds the block with its defaults: 8-bit bytes and two synchronizer stages. With a half serial period of eight system clocks, every pin change settles through the synchronizers and the edge registers before the next change arrives. That spacing lets the bench change the pause pin on either clock level and watch deferral and release one level at a time. It also makes bit-exact output sampling possible just before each rise. Byte width 8 gives a 3-bit count, so wrap-around at the byte boundary is reached in every transfer.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    typedef enum logic [1:0] {
        FE_UNARMED = 2'd0,
        FE_IDLE    = 2'd1,
        FE_ACTIVE  = 2'd2,
        FE_HOLD    = 2'd3
    } fe_state_t;

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int           WIDTH   = 4,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= RST_VAL;
                end else if (s == 0) begin
                    chain[s] <= d_i;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
    import spi_fe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      csn_s,
    input  logic      sclk_s,
    input  logic      holdn_s,
    output fe_state_t state_o,
    output logic      frame_start_o,
    output logic      frame_clear_o,
    output logic      edge_en_o
);

    fe_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FE_UNARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FE_UNARMED: if (csn_s) state_d = FE_IDLE;
            FE_IDLE:    if (!csn_s) state_d = FE_ACTIVE;
            FE_ACTIVE: begin
                if (csn_s)                   state_d = FE_IDLE;
                else if (!holdn_s && !sclk_s) state_d = FE_HOLD;
            end
            FE_HOLD: begin
                if (csn_s)                   state_d = FE_IDLE;
                else if (holdn_s && !sclk_s)  state_d = FE_ACTIVE;
            end
            default: state_d = FE_UNARMED;
        endcase
    end

    always_comb begin
        frame_start_o = 1'b0;
        frame_clear_o = 1'b0;
        edge_en_o     = 1'b0;
        unique case (state_q)
            FE_UNARMED: ;
            FE_IDLE:    frame_start_o = !csn_s;
            FE_ACTIVE: begin
                frame_clear_o = csn_s;
                edge_en_o     = !csn_s;
            end
            FE_HOLD:    frame_clear_o = csn_s;
            default: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/spi_fe_shifter.sv
module spi_fe_shifter #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              frame_start_i,
    input  logic              frame_clear_i,
    input  logic              edge_en_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    output logic [CNT_W-1:0]  bit_cnt_o,
    output logic              tx_bit_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sclk_prev_q;
    logic              rise, fall;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] rx_sh_q, tx_sh_q, rx_byte_q;
    logic              rx_valid_q;

    assign rise = sclk_s && !sclk_prev_q;
    assign fall = !sclk_s && sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            rx_sh_q    <= '0;
            tx_sh_q    <= '0;
            rx_byte_q  <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            if (frame_start_i) begin
                cnt_q   <= '0;
                tx_sh_q <= tx_byte_i;
            end else if (frame_clear_i) begin
                cnt_q <= '0;
            end else if (edge_en_i) begin
                if (rise) begin
                    rx_sh_q <= {rx_sh_q[BYTE_W-2:0], mosi_s};
                    if (cnt_q == LAST_BIT) begin
                        cnt_q      <= '0;
                        rx_byte_q  <= {rx_sh_q[BYTE_W-2:0], mosi_s};
                        rx_valid_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                if (fall) begin
                    if (cnt_q == '0) begin
                        tx_sh_q <= tx_byte_i;
                    end else begin
                        tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign rx_byte_o  = rx_byte_q;
    assign rx_valid_o = rx_valid_q;
    assign bit_cnt_o  = cnt_q;
    assign tx_bit_o   = tx_sh_q[BYTE_W-1];

endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
    import spi_fe_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              csn_i,
    input  logic              holdn_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    output logic [CNT_W-1:0]  bit_cnt_o,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic              selected_o,
    output logic              hold_o
);

    // pin order in the synchronizer vector: {holdn, csn, mosi, sclk}
    // select resets to its asserted level so a low pin at reset never arms
    localparam logic [3:0] PIN_RST = 4'b1000;

    logic [3:0] pins_s;
    logic       sclk_s, mosi_s, csn_s, holdn_s;
    fe_state_t  state;
    logic       frame_start, frame_clear, edge_en;
    logic       tx_bit;

    spi_fe_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({holdn_i, csn_i, mosi_i, sclk_i}),
        .q_o  (pins_s)
    );

    assign sclk_s  = pins_s[0];
    assign mosi_s  = pins_s[1];
    assign csn_s   = pins_s[2];
    assign holdn_s = pins_s[3];

    spi_fe_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .csn_s        (csn_s),
        .sclk_s       (sclk_s),
        .holdn_s      (holdn_s),
        .state_o      (state),
        .frame_start_o(frame_start),
        .frame_clear_o(frame_clear),
        .edge_en_o    (edge_en)
    );

    spi_fe_shifter #(
        .BYTE_W(BYTE_W),
        .CNT_W (CNT_W)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_s       (sclk_s),
        .mosi_s       (mosi_s),
        .frame_start_i(frame_start),
        .frame_clear_i(frame_clear),
        .edge_en_i    (edge_en),
        .tx_byte_i    (tx_byte_i),
        .rx_byte_o    (rx_byte_o),
        .rx_valid_o   (rx_valid_o),
        .bit_cnt_o    (bit_cnt_o),
        .tx_bit_o     (tx_bit)
    );

    assign miso_oe_o  = (state == FE_ACTIVE);
    assign miso_o     = miso_oe_o ? tx_bit : 1'b0;
    assign selected_o = (state == FE_ACTIVE) || (state == FE_HOLD);
    assign hold_o     = (state == FE_HOLD);

endmodule

// File: rtl/spi_hold_frontend_chk.sv
module spi_hold_frontend_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk_i,
    input logic             csn_i,
    input logic             rx_valid_o,
    input logic [CNT_W-1:0] bit_cnt_o,
    input logic             miso_oe_o,
    input logic             selected_o,
    input logic             hold_o
);

    // R5
    oe_off_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_i && $past(csn_i, 1) && $past(csn_i, 2) && $past(csn_i, 3)) |-> !miso_oe_o);

    // R7
    hold_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> !miso_oe_o);

    // R7
    hold_count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && $past(hold_o)) |-> $stable(bit_cnt_o));

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R3
    strobe_count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (bit_cnt_o == '0));

    // R6
    hold_entry_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> !$past(sclk_i, 3));

    // R8
    hold_exit_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_o) && selected_o) |-> !$past(sclk_i, 3));

endmodule

bind spi_hold_frontend spi_hold_frontend_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (sclk_i),
    .csn_i     (csn_i),
    .rx_valid_o(rx_valid_o),
    .bit_cnt_o (bit_cnt_o),
    .miso_oe_o (miso_oe_o),
    .selected_o(selected_o),
    .hold_o    (hold_o)
);

// File: tb/spi_hold_frontend_bench.sv
module spi_hold_frontend_bench;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_i = 1'b0;
    logic       mosi_i = 1'b0;
    logic       csn_i = 1'b0;
    logic       holdn_i = 1'b1;
    logic [7:0] tx_byte_i = 8'h00;
    logic [7:0] rx_byte_o;
    logic       rx_valid_o;
    logic [2:0] bit_cnt_o;
    logic       miso_o, miso_oe_o, selected_o, hold_o;

    int n_chk = 0;
    int n_fail = 0;
    int n_strb = 0;
    bit done = 1'b0;
    logic [7:0] exp_q [$];

    always #2.5 clk = ~clk;

    spi_hold_frontend u_spi_hold_frontend (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .mosi_i(mosi_i),
        .csn_i(csn_i), .holdn_i(holdn_i), .tx_byte_i(tx_byte_i),
        .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o), .bit_cnt_o(bit_cnt_o),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o), .selected_o(selected_o),
        .hold_o(hold_o)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: R3 byte order and value
    always @(negedge clk) begin
        if (rst_n && rx_valid_o) begin
            n_strb++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected byte", int'(rx_byte_o), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_byte_o == e, "R3 received byte", int'(rx_byte_o), int'(e));
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_to(logic v);
        sclk_i = v;
        tick(H);
    endtask

    task automatic bit_xfer(logic b, logic e, string req);
        if (sclk_i) sclk_to(1'b0);
        mosi_i = b;
        tick(H);
        chk(miso_oe_o && (miso_o == e), req, int'({miso_oe_o, miso_o}), int'({1'b1, e}));
        sclk_to(1'b1);
    endtask

    task automatic bits(logic [7:0] d, logic [7:0] e, int hi, int lo, string req);
        for (int i = hi; i >= lo; i--) bit_xfer(d[i], e[i], req);
    endtask

    task automatic byte_xfer(logic [7:0] d, logic [7:0] e, logic [7:0] nxt, string req);
        exp_q.push_back(d);
        bits(d, e, 7, 0, req);
        tx_byte_i = nxt;
    endtask

    task automatic sel();
        csn_i = 1'b0;
        tick(H);
    endtask

    task automatic desel(logic idle_hi);
        if (!idle_hi && sclk_i) sclk_to(1'b0);
        if (idle_hi && !sclk_i) sclk_to(1'b1);
        csn_i = 1'b1;
        tick(H);
    endtask

    initial begin
        int s0;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk(!miso_oe_o && !rx_valid_o && !selected_o && !hold_o && bit_cnt_o == 0,
            "R1 reset outputs", int'({miso_oe_o, rx_valid_o, selected_o, hold_o, bit_cnt_o}), 0);

        // R2 select low through reset is ignored
        s0 = n_strb;
        for (int i = 0; i < 8; i++) begin
            mosi_i = i[0];
            sclk_to(1'b1);
            sclk_to(1'b0);
        end
        chk(n_strb == s0 && !selected_o, "R2 unarmed select", int'({n_strb - s0, selected_o}), 0);
        csn_i = 1'b1;
        tick(H);
        chk(!miso_oe_o, "R5 oe off while deselected", int'(miso_oe_o), 0);
        tx_byte_i = 8'h3C;
        sel();
        chk(selected_o == 1'b1, "R2 armed select", int'(selected_o), 1);

        // R3/R4 idle-low mode, two bytes, tx reload at boundary
        byte_xfer(8'hA5, 8'h3C, 8'hE1, "R4 out bit");
        chk(bit_cnt_o == 0, "R3 count wraps", int'(bit_cnt_o), 0);
        byte_xfer(8'h0F, 8'hE1, 8'h00, "R4 reload bit");
        desel(1'b0);
        chk(!miso_oe_o && !selected_o, "R5 deselect", int'({miso_oe_o, selected_o}), 0);

        // R10 idle-high mode
        sclk_to(1'b1);
        tx_byte_i = 8'h6B;
        sel();
        byte_xfer(8'hC7, 8'h6B, 8'h81, "R10 out bit");
        byte_xfer(8'h12, 8'h81, 8'h00, "R10 second out bit");
        desel(1'b1);
        sclk_to(1'b0);

        // R6 deferred entry, R7 ignore, R8 deferred release
        tx_byte_i = 8'h96;
        sel();
        exp_q.push_back(8'hC3);
        bits(8'hC3, 8'h96, 7, 5, "R4 before hold");
        chk(bit_cnt_o == 3, "R3 partial count", int'(bit_cnt_o), 3);
        holdn_i = 1'b0;
        tick(H);
        chk(!hold_o, "R6 entry deferred while clock high", int'(hold_o), 0);
        sclk_to(1'b0);
        chk(hold_o, "R6 entry once clock low", int'(hold_o), 1);
        chk(!miso_oe_o, "R7 oe off in hold", int'(miso_oe_o), 0);
        s0 = n_strb;
        for (int i = 0; i < 6; i++) begin
            mosi_i = ~mosi_i;
            sclk_to(1'b1);
            sclk_to(1'b0);
        end
        chk(bit_cnt_o == 3 && n_strb == s0, "R7 edges ignored", int'(bit_cnt_o), 3);
        sclk_to(1'b1);
        holdn_i = 1'b1;
        tick(H);
        chk(hold_o, "R8 release deferred while clock high", int'(hold_o), 1);
        sclk_to(1'b0);
        chk(!hold_o && miso_oe_o, "R8 release once clock low", int'({hold_o, miso_oe_o}), 1);
        chk(miso_o == 1'b1, "R7 output not shifted in hold", int'(miso_o), 1);
        bits(8'hC3, 8'h96, 4, 0, "R7 resumed out bit");
        desel(1'b0);

        // R9 select rise in hold
        tx_byte_i = 8'h44;
        sel();
        s0 = n_strb;
        bits(8'hFF, 8'h44, 7, 3, "R4 pre abort");
        sclk_to(1'b0);
        holdn_i = 1'b0;
        tick(H);
        chk(hold_o, "R6 immediate entry clock low", int'(hold_o), 1);
        csn_i = 1'b1;
        tick(H);
        chk(!selected_o && !hold_o && bit_cnt_o == 0, "R9 abort clears",
            int'({selected_o, hold_o, bit_cnt_o}), 0);
        holdn_i = 1'b1;
        tick(H);
        tx_byte_i = 8'h5A;
        sel();
        byte_xfer(8'h3E, 8'h5A, 8'h00, "R9 fresh byte out");
        desel(1'b0);
        chk(n_strb == s0 + 1, "R9 only the fresh byte strobes", n_strb - s0, 1);

        // R11 select rise mid-byte
        tx_byte_i = 8'hF0;
        sel();
        s0 = n_strb;
        bits(8'hAA, 8'hF0, 7, 4, "R4 partial");
        desel(1'b0);
        chk(bit_cnt_o == 0 && n_strb == s0, "R11 partial discarded",
            int'({n_strb - s0, bit_cnt_o}), 0);
        tx_byte_i = 8'h99;
        sel();
        byte_xfer(8'h71, 8'h99, 8'h00, "R11 next out");
        desel(1'b0);

        tick(4);
        chk(exp_q.size() == 0, "R3 all bytes received", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule